// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer of 9-bit words that sits between two unrelated clock domains. A producer writes on its own clock and a consumer reads on another. Each access is qualified by a pair of enables: an active-low and an active-high enable on the write side, and two active-low enables on the read side. The read word lands in an output register. A separate output enable either drives that register onto the data pins or releases them to high impedance.

Four active-low status flags describe the fill level. Empty and almost-empty belong to the read clock. Full and almost-full belong to the write clock. The pointers cross between the domains as Gray code through two-flop synchronisers. Because of this, each flag can lag the true level, but only in the safe direction. The almost-empty and almost-full thresholds come from two offset inputs, which a neighbouring register block supplies. While that block reports that no offsets have been loaded, both offsets fall back to 7 words.

Top module: `afifo_flags`

## Requirements
- R1: A word is stored on a rising `wclk` edge only when `wr_en_n` is 0 and `wr_en` is 1. Any other combination stores nothing.
- R2: A read takes place on a rising `rclk` edge only when `rd_en_a_n` and `rd_en_b_n` are both 0. After that edge, the output register holds the word that was read.
- R3: Words leave the buffer in the order in which they were stored.
- R4: A write attempted while `full_n` is 0 is discarded. The word never appears at the output, and the write-side level never exceeds DEPTH.
- R5: A read attempted while `empty_n` is 0 is ignored. The output register keeps the last word that was validly read.
- R6: `empty_n` is 0 whenever the buffer holds no word, and it is registered on `rclk`. `full_n` is 0 whenever the buffer holds DEPTH words, and it is registered on `wclk`. Once the pointers have settled, `empty_n` is 1 for any non-zero level and `full_n` is 1 for any level below DEPTH.
- R7: `aempty_n` is registered on `rclk`. It is 0 when the level seen by the read side is at or below the empty offset.
- R8: `afull_n` is registered on `wclk`. It is 0 when the level seen by the write side is at or above DEPTH minus the full offset.
- R9: While `ofs_load` is 0, both offsets are 7. While `ofs_load` is 1, the offsets are taken from `ae_ofs` and `af_ofs`.
- R10: While `rst_n` is 0, the pointers clear, `empty_n` and `aempty_n` are 0, `full_n` and `afull_n` are 1, and the output register is 0.
- R11: When `oe_n` is 0, `rd_data` carries the output register. When `oe_n` is 1, `rd_data` is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_n | input | 1 | Write enable, active low |
| wr_en | input | 1 | Write enable, active high |
| wr_data | input | 9 | Word to store |
| rd_en_a_n | input | 1 | First read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output drive enable, active low |
| ofs_load | input | 1 | 1 when the offset inputs hold programmed values |
| ae_ofs | input | AW (6 by default) | Almost-empty offset, in words |
| af_ofs | input | AW (6 by default) | Almost-full offset, in words |
| rd_data | output | 9 | Output register, tri-stated by `oe_n` |
| empty_n | output | 1 | Empty flag, active low, read clock |
| aempty_n | output | 1 | Almost-empty flag, active low, read clock |
| afull_n | output | 1 | Almost-full flag, active low, write clock |
| full_n | output | 1 | Full flag, active low, write clock |

## Verification
The assertions check, on every cycle, the conservative side of each flag:
- a deasserted empty or almost-empty flag never hides a read-side level that is too low;
- a deasserted full or almost-full flag never hides a write-side level that is too high;
- the write-side level never exceeds DEPTH;
- the output register does not move while empty is asserted;
- the reset values hold.

Only the bench scenarios show the rest. These are exact flag values once the pointers have settled, the threshold switch between default and loaded offsets, the rejection of partly qualified enables, the word order across a full-to-empty drain, and the tri-state of the data pins.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

  localparam int WORD_W = 9;
  localparam int PTR_W  = 16;   // wide enough for any pointer up to 8192 deep plus one wrap bit

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [PTR_W-1:0]  ptr_t;

  // binary count to reflected Gray code
  function automatic ptr_t bin2gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  // reflected Gray code back to binary, MSB downward
  function automatic ptr_t gray2bin(ptr_t g);
    ptr_t b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // level between two wrap-extended pointers, truncated to pw bits by the caller
  function automatic ptr_t level_of(ptr_t head, ptr_t tail);
    return head - tail;
  endfunction

endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/afifo_ram.sv
module afifo_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic                 wclk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  afifo_pkg::word_t     wdata,
  input  logic [AW-1:0]        raddr,
  output afifo_pkg::word_t     rdata
);

  afifo_pkg::word_t mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/afifo_wr_side.sv
module afifo_wr_side #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int PW    = AW + 1
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [PW-1:0] rgray_sync,
  input  logic [PW-1:0] af_thr,
  output logic          wr_fire,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic [PW-1:0] wr_level,
  output logic          full_n,
  output logic          afull_n
);
  import afifo_pkg::*;

  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

  logic [PW-1:0] wbin, wbin_nx, rbin_seen, lvl_nx;

  assign wr_fire   = wr_req & full_n;                     // R4
  assign wbin_nx   = wbin + PW'(wr_fire);
  assign rbin_seen = PW'(gray2bin(ptr_t'(rgray_sync)));
  assign lvl_nx    = PW'(level_of(ptr_t'(wbin_nx), ptr_t'(rbin_seen)));
  assign wr_level  = PW'(level_of(ptr_t'(wbin), ptr_t'(rbin_seen)));
  assign waddr     = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= PW'(bin2gray(ptr_t'(wbin_nx)));
      full_n  <= (lvl_nx != FULL_LVL);                    // R6
      afull_n <= !(lvl_nx >= af_thr);                     // R8
    end
  end

endmodule

// File: rtl/afifo_rd_side.sv
module afifo_rd_side #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int PW    = AW + 1
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [PW-1:0] wgray_sync,
  input  logic [PW-1:0] ae_thr,
  output logic          rd_fire,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic [PW-1:0] rd_level,
  output logic          empty_n,
  output logic          aempty_n
);
  import afifo_pkg::*;

  logic [PW-1:0] rbin, rbin_nx, wbin_seen, lvl_nx;

  assign rd_fire   = rd_req & empty_n;                    // R5
  assign rbin_nx   = rbin + PW'(rd_fire);
  assign wbin_seen = PW'(gray2bin(ptr_t'(wgray_sync)));
  assign lvl_nx    = PW'(level_of(ptr_t'(wbin_seen), ptr_t'(rbin_nx)));
  assign rd_level  = PW'(level_of(ptr_t'(wbin_seen), ptr_t'(rbin)));
  assign raddr     = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= PW'(bin2gray(ptr_t'(rbin_nx)));
      empty_n  <= (lvl_nx != '0);                         // R6
      aempty_n <= !(lvl_nx <= ae_thr);                    // R7
    end
  end

endmodule

// File: rtl/afifo_flags.sv
module afifo_flags #(
  parameter  int DEPTH   = 64,   // power of two, 64 to 8192
  parameter  int DEF_OFS = 7,
  localparam int AW      = $clog2(DEPTH),
  localparam int PW      = AW + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic          wr_en,
  input  logic [8:0]    wr_data,
  input  logic          rd_en_a_n,
  input  logic          rd_en_b_n,
  input  logic          oe_n,
  input  logic          ofs_load,
  input  logic [AW-1:0] ae_ofs,
  input  logic [AW-1:0] af_ofs,
  output wire  [8:0]    rd_data,
  output logic          empty_n,
  output logic          aempty_n,
  output logic          afull_n,
  output logic          full_n
);
  import afifo_pkg::*;

  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
  localparam logic [AW-1:0] OFS_DEF  = AW'(DEF_OFS);

  // named internal events
  logic          wr_req, rd_req, wr_fire, rd_fire;
  logic [AW-1:0] waddr, raddr, ae_sel, af_sel;
  logic [PW-1:0] wgray, rgray, wgray_rs, rgray_ws;
  logic [PW-1:0] wr_level, rd_level, ae_thr, af_thr;
  word_t         ram_q, rd_q;

  assign wr_req = !wr_en_n && wr_en;                      // R1
  assign rd_req = !rd_en_a_n && !rd_en_b_n;               // R2

  // R9 threshold source
  assign ae_sel = ofs_load ? ae_ofs : OFS_DEF;
  assign af_sel = ofs_load ? af_ofs : OFS_DEF;
  assign ae_thr = {1'b0, ae_sel};
  assign af_thr = FULL_LVL - {1'b0, af_sel};

  afifo_wr_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wr_req(wr_req), .rgray_sync(rgray_ws),
    .af_thr(af_thr), .wr_fire(wr_fire), .waddr(waddr), .wgray(wgray),
    .wr_level(wr_level), .full_n(full_n), .afull_n(afull_n)
  );

  afifo_rd_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .rd_req(rd_req), .wgray_sync(wgray_rs),
    .ae_thr(ae_thr), .rd_fire(rd_fire), .raddr(raddr), .rgray(rgray),
    .rd_level(rd_level), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  afifo_sync #(.W(PW), .STAGES(2)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_rs)
  );

  afifo_sync #(.W(PW), .STAGES(2)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_ws)
  );

  afifo_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(ram_q)
  );

  // R2 R5 R10 output register
  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_fire) rd_q <= ram_q;
  end

  // R11
  assign rd_data = oe_n ? 'z : rd_q;

endmodule

// File: rtl/afifo_flags_chk.sv
module afifo_flags_chk #(
  parameter int DEPTH = 64,
  parameter int PW    = 7
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          full_n,
  input logic          afull_n,
  input logic          empty_n,
  input logic          aempty_n,
  input logic [PW-1:0] wr_level,
  input logic [PW-1:0] rd_level,
  input logic [PW-1:0] af_thr,
  input logic [PW-1:0] ae_thr,
  input logic [8:0]    rd_q
);

  // R4
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_level <= PW'(DEPTH));

  // R6
  full_flag_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    full_n |-> wr_level < PW'(DEPTH));

  // R6
  empty_flag_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    empty_n |-> rd_level != '0);

  // R5
  hold_on_empty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(rd_q));

  // R7
  aempty_flag_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (aempty_n && $stable(ae_thr)) |-> rd_level > ae_thr);

  // R8
  afull_flag_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (afull_n && $stable(af_thr)) |-> wr_level < af_thr);

  // R10
  always @(posedge rclk) begin
    if (!rst_n) begin
      rst_rd_chk: assert (!empty_n && !aempty_n && rd_q == '0);
    end
  end

  // R10
  always @(posedge wclk) begin
    if (!rst_n) begin
      rst_wr_chk: assert (full_n && afull_n);
    end
  end

endmodule

bind afifo_flags afifo_flags_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .full_n(full_n), .afull_n(afull_n),
  .empty_n(empty_n), .aempty_n(aempty_n), .wr_level(wr_level), .rd_level(rd_level),
  .af_thr(af_thr), .ae_thr(ae_thr), .rd_q(rd_q)
);

// File: tb/afifo_flags_tb.sv
module afifo_flags_tb;

  localparam int DEPTH = 64;
  localparam int AW    = 6;

  logic          wclk = 0, rclk = 0, rst_n = 1;
  logic          wr_en_n = 1, wr_en = 0, rd_en_a_n = 1, rd_en_b_n = 1, oe_n = 0;
  logic          ofs_load = 0;
  logic [AW-1:0] ae_ofs = '0, af_ofs = '0;
  logic [8:0]    wr_data = '0;
  wire  [8:0]    rd_data;
  logic          empty_n, aempty_n, afull_n, full_n;

  int nchk = 0, nerr = 0;
  bit finished = 0;
  logic [8:0] seq = 9'd1;

  // behavioural reference
  logic [8:0] mq[$];
  logic [8:0] exp_q = '0;

  afifo_flags #(.DEPTH(DEPTH)) u_dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en_n(wr_en_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n), .oe_n(oe_n),
    .ofs_load(ofs_load), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .rd_data(rd_data),
    .empty_n(empty_n), .aempty_n(aempty_n), .afull_n(afull_n), .full_n(full_n)
  );

  // 125 MHz on both sides, read clock offset by 3 ns
  initial forever #4 wclk = ~wclk;
  initial begin #3; forever #4 rclk = ~rclk; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // model: store on qualified write while not full (R1, R4)
  always @(posedge wclk) begin
    if (!rst_n) mq.delete();
    else if (!wr_en_n && wr_en && full_n) mq.push_back(wr_data);
  end

  // model: fetch on qualified read while not empty (R2, R5)
  always @(posedge rclk) begin
    if (!rst_n) begin
      mq.delete();
      exp_q = '0;
    end else if (!rd_en_a_n && !rd_en_b_n && empty_n) begin
      if (mq.size() > 0) exp_q = mq.pop_front();
      else chk(0, "R6 empty_n high with nothing stored", 1, 0);
    end
  end

  // per-cycle comparison on the read side (R2, R3, R6)
  always @(negedge rclk) begin
    if (rst_n && !oe_n) chk(rd_data == exp_q, "R3 word order", int'(rd_data), int'(exp_q));
    if (rst_n) chk(!(empty_n && mq.size() == 0), "R6 empty", int'(empty_n), 0);
  end

  // per-cycle comparison on the write side (R6)
  always @(negedge wclk) begin
    if (rst_n) chk(!(full_n && mq.size() == DEPTH), "R6 full", int'(full_n), 0);
  end

  task automatic wr_words(input int n, input bit en_n = 0, input bit en = 1);
    @(posedge wclk); #1;
    for (int i = 0; i < n; i++) begin
      wr_en_n = en_n; wr_en = en; wr_data = seq; seq = seq + 9'd1;
      @(posedge wclk); #1;
    end
    wr_en_n = 1; wr_en = 0;
  endtask

  task automatic rd_words(input int n, input bit a_n = 0, input bit b_n = 0);
    @(posedge rclk); #1;
    for (int i = 0; i < n; i++) begin
      rd_en_a_n = a_n; rd_en_b_n = b_n;
      @(posedge rclk); #1;
    end
    rd_en_a_n = 1; rd_en_b_n = 1;
  endtask

  // exact flag values once the pointers have crossed (R6 R7 R8 R9)
  task automatic settle_check(input string tag);
    int n, ae, af;
    repeat (8) @(posedge wclk);
    @(negedge rclk);
    n  = mq.size();
    ae = ofs_load ? int'(ae_ofs) : 7;
    af = ofs_load ? int'(af_ofs) : 7;
    chk(empty_n  == (n != 0),             {tag, " R6 empty_n"},  int'(empty_n),  int'(n != 0));
    chk(full_n   == (n != DEPTH),         {tag, " R6 full_n"},   int'(full_n),   int'(n != DEPTH));
    chk(aempty_n == !(n <= ae),           {tag, " R7 aempty_n"}, int'(aempty_n), int'(!(n <= ae)));
    chk(afull_n  == !(n >= DEPTH - af),   {tag, " R8 afull_n"},  int'(afull_n),  int'(!(n >= DEPTH - af)));
  endtask

  initial begin
    #1 rst_n = 0;
    repeat (5) @(posedge wclk);
    #1;
    // R10 reset state
    chk(empty_n == 0 && aempty_n == 0, "R10 read-side flags", int'({empty_n, aempty_n}), 0);
    chk(full_n == 1 && afull_n == 1, "R10 write-side flags", int'({full_n, afull_n}), 3);
    chk(rd_data == 9'd0, "R10 output register", int'(rd_data), 0);
    rst_n = 1;

    // R5 read on empty is ignored
    rd_words(3);
    @(negedge rclk);
    chk(rd_data == 9'd0, "R5 read on empty", int'(rd_data), 0);

    // R1 partly qualified writes store nothing
    wr_words(3, 1, 1);
    wr_words(3, 0, 0);
    settle_check("R1 no write");

    // R7 R9 default almost-empty threshold: 7 words, then 8
    wr_words(7);
    settle_check("R9 level 7");
    wr_words(1);
    settle_check("R9 level 8");

    // R2 partly qualified reads fetch nothing
    rd_words(2, 1, 0);
    rd_words(2, 0, 1);
    @(negedge rclk);
    chk(rd_data == 9'd0, "R2 no read", int'(rd_data), 0);
    rd_words(3);
    @(negedge rclk);
    chk(rd_data == exp_q && exp_q != 0, "R2 valid read", int'(rd_data), int'(exp_q));

    // R8 R9 default almost-full threshold at DEPTH-7
    wr_words(51);
    settle_check("R8 level 56");
    wr_words(1);
    settle_check("R8 level 57");

    // R4 fill and overrun
    wr_words(7);
    wr_words(3);
    settle_check("R4 full");
    chk(mq.size() == DEPTH, "R4 stored count", mq.size(), DEPTH);

    // drain: per-cycle compare shows order and no overrun word (R3, R4)
    rd_words(DEPTH);
    settle_check("R3 drained");
    rd_words(2);
    @(negedge rclk);
    chk(rd_data == exp_q && exp_q != 0, "R5 holds last word", int'(rd_data), int'(exp_q));

    // R9 loaded offsets
    ofs_load = 1; ae_ofs = 6'd20; af_ofs = 6'd10;
    wr_words(20);
    settle_check("R9 loaded 20");
    wr_words(1);
    settle_check("R9 loaded 21");
    wr_words(32);
    settle_check("R9 loaded 53");
    wr_words(1);
    settle_check("R9 loaded 54");

    // R11 output drive
    oe_n = 1;
    @(negedge rclk);
    chk(rd_data !== exp_q, "R11 released", int'(rd_data), -1);
    oe_n = 0;
    @(negedge rclk);
    chk(rd_data === exp_q, "R11 driven", int'(rd_data), int'(exp_q));

    // R10 reset with words stored
    @(posedge wclk); #1;
    rst_n = 0;
    #2;
    chk(empty_n == 0 && aempty_n == 0 && full_n == 1 && afull_n == 1,
        "R10 flags after mid reset", int'({empty_n, aempty_n, full_n, afull_n}), 3);
    chk(rd_data == 9'd0, "R10 output after mid reset", int'(rd_data), 0);
    repeat (3) @(posedge wclk);
    #1 rst_n = 1;
    ofs_load = 0;
    settle_check("R10 after reset");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule